// File: doc/BRIEF.md
# Dual-Port Address-Contention Busy Arbiter

This block sits beside a two-port memory. Each port has its own enable and address. When both ports are enabled and present the same address, the block decides which port keeps the location. It flags the other port with an active-low busy signal. The winner is the port whose claim existed first. A claim starts when the port's enable rises, or when its address changes while enabled. When both claims start in the same cycle, a parameter picks the winner. The decision is registered, so busy is visible one clock after the contending cycle.

A mode input selects master or slave operation. In master mode the block drives its own decision onto the busy outputs. In slave mode the busy outputs copy two external active-low busy inputs. Several devices that widen the word can then share one master's outcome. In either mode a port's write request becomes a write grant only while that port is enabled and its busy is high.

Top module: `busy_arbiter`

## Requirements
- R1: In master mode, if either enable is low or the addresses differ at a clock edge, both `busyLN` and `busyRN` are high (inactive) after that edge.
- R2: In master mode, when one port starts a claim on the address already held by the other port, the newcomer's busy goes low after that edge and the holder's busy stays high.
- R3: A claim starts by a rising enable or by an address change while enabled; either kind of start that creates a match produces busy in the same way.
- R4: When both claims start in the same cycle on one address, exactly one port wins. With `TIE_RIGHT`=0 the left port wins (`busyRN` low, `busyLN` high). With `TIE_RIGHT`=1 the right port wins.
- R5: While the winner keeps its enable and address unchanged and the match persists, the decision does not change on later edges.
- R6: When the winner drops its enable or moves its address away, the loser's busy returns high after the next edge.
- R7: With `isMaster` low, `busyLN` equals `busyInLN` and `busyRN` equals `busyInRN` in the same cycle, whatever the internal decision is.
- R8: `wrGrantL` is 1 only when `wrReqL`, `ceL` and `busyLN` are all 1. The same holds for the right port. A port with busy low never gets a write grant.
- R9: While `rstN` is low, both busy outputs are high in master mode. Reset also clears the history of claims, so claims still present when reset releases count as simultaneous starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isMaster | input | 1 | 1 = master (drive own decision), 0 = slave (follow busy inputs) |
| ceL | input | 1 | Left port enable, active high |
| addrL | input | ADDR_W | Left port address |
| wrReqL | input | 1 | Left port write request |
| busyInLN | input | 1 | External left busy, active low, used in slave mode |
| ceR | input | 1 | Right port enable, active high |
| addrR | input | ADDR_W | Right port address |
| wrReqR | input | 1 | Right port write request |
| busyInRN | input | 1 | External right busy, active low, used in slave mode |
| busyLN | output | 1 | Left port busy, active low |
| busyRN | output | 1 | Right port busy, active low |
| wrGrantL | output | 1 | Left write qualified |
| wrGrantR | output | 1 | Right write qualified |

## Verification
Two functions can fall in the same cycle: the first-come ordering and the tie-break. They meet when both ports start a claim in one cycle, or when the held decision must be re-judged because both ports move their addresses to a new common location together. The bench provokes this in three ways: both enables rising at once, both addresses jumping together, and claims that survive a reset release. It runs a second instance with the opposite tie parameter and judges each outcome from which busy output drops one edge later. It also checks that a loser leaving and returning is still ordered by arrival, not by the tie rule.

// File: rtl/busy_arb_pkg.sv
package busy_arb_pkg;

  localparam int NUM_PORTS = 2;
  localparam int PORT_L    = 0;
  localparam int PORT_R    = 1;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Detector -> control: contention and per-port claim starts
  typedef struct packed {
    logic                 match;
    logic [NUM_PORTS-1:0] fresh;
  } contEvt_t;

  // Control -> datapath: per-port hold-off strobes (1 = this port loses)
  typedef struct packed {
    logic [NUM_PORTS-1:0] holdOff;
  } busyStrobe_t;

endpackage

// File: rtl/contention_detect.sv
module contention_detect
  import busy_arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_PORTS-1:0]                portEn,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    portAddr,
  output contEvt_t                            evt
);

  logic [NUM_PORTS-1:0]             prevEn;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] prevAddr;
  logic [NUM_PORTS-1:0]             freshVec;

  // One history register set per port; a claim starts on a rising enable
  // or on an address change while the enable stays high.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevEn[p]   <= 1'b0;
        prevAddr[p] <= '0;
      end else begin
        prevEn[p]   <= portEn[p];
        prevAddr[p] <= portAddr[p];
      end
    end

    assign freshVec[p] = portEn[p] &&
                         (!prevEn[p] || (portAddr[p] != prevAddr[p]));
  end

  assign evt.match = portEn[PORT_L] && portEn[PORT_R] &&
                     (portAddr[PORT_L] == portAddr[PORT_R]);
  assign evt.fresh = freshVec;

endmodule

// File: rtl/owner_ctrl.sv
module owner_ctrl
  import busy_arb_pkg::*;
#(
  parameter bit TIE_RIGHT = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  contEvt_t    evt,
  output busyStrobe_t strobe
);

  localparam owner_e TIE_OWNER = TIE_RIGHT ? OWN_RIGHT : OWN_LEFT;

  owner_e owner, ownerNext;
  logic   freshL, freshR;

  assign freshL = evt.fresh[PORT_L];
  assign freshR = evt.fresh[PORT_R];

  always_comb begin
    ownerNext = owner;
    if (!evt.match)                           ownerNext = OWN_NONE;
    else if (owner == OWN_LEFT  && !freshL)   ownerNext = OWN_LEFT;
    else if (owner == OWN_RIGHT && !freshR)   ownerNext = OWN_RIGHT;
    else if (freshR && !freshL)               ownerNext = OWN_LEFT;
    else if (freshL && !freshR)               ownerNext = OWN_RIGHT;
    else                                      ownerNext = TIE_OWNER;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owner <= OWN_NONE;
    else       owner <= ownerNext;
  end

  assign strobe.holdOff[PORT_L] = (owner == OWN_RIGHT);
  assign strobe.holdOff[PORT_R] = (owner == OWN_LEFT);

  // R1: no contention clears the decision on the next edge
  p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    !evt.match |=> owner == OWN_NONE);

  // R2: a late claim against an established one loses
  p_first_come_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evt.match && freshR && !freshL) |=> owner == OWN_LEFT);

  // R4: simultaneous starts go to the configured side
  p_tie_break_r4: assert property (@(posedge clk) disable iff (!rstN)
    (evt.match && freshL && freshR) |=> owner == TIE_OWNER);

  // R5: an unchanged winner keeps the location
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (evt.match && owner == OWN_RIGHT && !freshR) |=> owner == OWN_RIGHT);

endmodule

// File: rtl/port_gate.sv
module port_gate
  import busy_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 isMaster,
  input  busyStrobe_t          strobe,
  input  logic [NUM_PORTS-1:0] busyInN,
  input  logic [NUM_PORTS-1:0] portEn,
  input  logic [NUM_PORTS-1:0] wrReq,
  output logic [NUM_PORTS-1:0] busyN,
  output logic [NUM_PORTS-1:0] wrGrant
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign busyN[p]   = isMaster ? ~strobe.holdOff[p] : busyInN[p];
    assign wrGrant[p] = wrReq[p] && portEn[p] && busyN[p];

    // R8: a busy port never writes
    p_write_block_r8: assert property (@(posedge clk) disable iff (!rstN)
      !busyN[p] |-> !wrGrant[p]);
  end

endmodule

// File: rtl/busy_arbiter.sv
module busy_arbiter
  import busy_arb_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter bit TIE_RIGHT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic              ceL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              wrReqL,
  input  logic              busyInLN,
  input  logic              ceR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              wrReqR,
  input  logic              busyInRN,
  output logic              busyLN,
  output logic              busyRN,
  output logic              wrGrantL,
  output logic              wrGrantR
);

  logic [NUM_PORTS-1:0]             portEn, wrReq, busyInN, busyN, wrGrant;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] portAddr;
  contEvt_t                         evt;
  busyStrobe_t                      strobe;

  assign portEn   = {ceR, ceL};
  assign portAddr = {addrR, addrL};
  assign wrReq    = {wrReqR, wrReqL};
  assign busyInN  = {busyInRN, busyInLN};

  contention_detect #(.ADDR_W(ADDR_W)) u_detect (
    .clk(clk), .rstN(rstN), .portEn(portEn), .portAddr(portAddr), .evt(evt)
  );

  owner_ctrl #(.TIE_RIGHT(TIE_RIGHT)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .strobe(strobe)
  );

  port_gate u_gate (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .strobe(strobe),
    .busyInN(busyInN), .portEn(portEn), .wrReq(wrReq),
    .busyN(busyN), .wrGrant(wrGrant)
  );

  assign busyLN   = busyN[PORT_L];
  assign busyRN   = busyN[PORT_R];
  assign wrGrantL = wrGrant[PORT_L];
  assign wrGrantR = wrGrant[PORT_R];

endmodule

// File: tb/tb_busy_arbiter.sv
module tb_busy_arbiter;

  localparam int AW = 14;
  localparam logic [AW-1:0] A = 14'h0010;
  localparam logic [AW-1:0] B = 14'h0020;

  typedef struct packed {
    logic          m, cl, cr;
    logic [AW-1:0] al, ar;
    logic          bil, bir, wl, wr;
    logic          ebl, ebr, egl, egr;
    logic [3:0]    req;
  } vec_t;

  // fields: master ceL ceR addrL addrR busyInL busyInR wrL wrR | expBusyL expBusyR expGrantL expGrantR | req
  localparam vec_t VECS [16] = '{
    '{1'b1,1'b0,1'b0,A,A,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd1}, // R1 idle
    '{1'b1,1'b1,1'b0,A,A,1'b1,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd1}, // R1 one side only
    '{1'b1,1'b1,1'b1,A,A,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd2}, // R2 right arrives late
    '{1'b1,1'b1,1'b1,A,A,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd5}, // R5 held
    '{1'b1,1'b1,1'b1,A,B,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd1}, // R1 addresses differ
    '{1'b1,1'b1,1'b1,A,A,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd3}, // R3 address-triggered
    '{1'b1,1'b0,1'b1,A,A,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b1, 4'd6}, // R6 winner leaves
    '{1'b1,1'b1,1'b1,A,A,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1, 4'd3}, // R3 enable-triggered, left late
    '{1'b1,1'b0,1'b0,A,A,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd1}, // R1
    '{1'b1,1'b1,1'b1,B,B,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd4}, // R4 both start
    '{1'b1,1'b1,1'b1,B,A,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd1}, // R1 loser moves off
    '{1'b1,1'b1,1'b1,B,B,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd2}, // R2 loser returns late
    '{1'b1,1'b1,1'b1,A,A,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd4}, // R4 both jump together
    '{1'b0,1'b1,1'b1,A,A,1'b0,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1, 4'd7}, // R7 slave follows
    '{1'b0,1'b1,1'b1,A,A,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd7}, // R7 slave idle inputs
    '{1'b0,1'b1,1'b1,A,A,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd8}  // R8 write blocked
  };

  logic clk = 1'b0;
  logic rstN;
  logic isMaster, ceL, ceR, wrReqL, wrReqR, busyInLN, busyInRN;
  logic [AW-1:0] addrL, addrR;
  logic busyLN, busyRN, wrGrantL, wrGrantR;
  logic tBusyLN, tBusyRN, tGrantL, tGrantR;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  busy_arbiter #(.ADDR_W(AW), .TIE_RIGHT(1'b0)) dut (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .ceL(ceL), .addrL(addrL), .wrReqL(wrReqL), .busyInLN(busyInLN),
    .ceR(ceR), .addrR(addrR), .wrReqR(wrReqR), .busyInRN(busyInRN),
    .busyLN(busyLN), .busyRN(busyRN), .wrGrantL(wrGrantL), .wrGrantR(wrGrantR)
  );

  busy_arbiter #(.ADDR_W(AW), .TIE_RIGHT(1'b1)) dutTie (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .ceL(ceL), .addrL(addrL), .wrReqL(wrReqL), .busyInLN(busyInLN),
    .ceR(ceR), .addrR(addrR), .wrReqR(wrReqR), .busyInRN(busyInRN),
    .busyLN(tBusyLN), .busyRN(tBusyRN), .wrGrantL(tGrantL), .wrGrantR(tGrantR)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input vec_t v);
    isMaster = v.m;  ceL = v.cl;  ceR = v.cr;
    addrL = v.al;    addrR = v.ar;
    busyInLN = v.bil; busyInRN = v.bir;
    wrReqL = v.wl;   wrReqR = v.wr;
  endtask

  initial begin
    #(8 * 20000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 0);
    $finish;
  end

  initial begin
    // R9: reset state, both ports already claiming one address
    rstN = 1'b0;
    drive('{1'b1,1'b1,1'b1,A,A,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd9});
    repeat (3) @(posedge clk);
    #2;
    check("R9 busyL in reset", busyLN, 1'b1);
    check("R9 busyR in reset", busyRN, 1'b1);
    check("R8 grantL in reset", wrGrantL, 1'b1);
    rstN = 1'b1;
    @(posedge clk); #2;
    // R4 and R9: surviving claims count as simultaneous starts
    check("R4 tie left busyL", busyLN, 1'b1);
    check("R4 tie left busyR", busyRN, 1'b0);
    check("R4 tie right busyL", tBusyLN, 1'b0);
    check("R4 tie right busyR", tBusyRN, 1'b1);
    check("R8 grantR blocked", wrGrantR, 1'b0);

    for (int i = 0; i < 16; i++) begin
      drive(VECS[i]);
      @(posedge clk); #2;
      check($sformatf("R%0d vec%0d busyL", VECS[i].req, i), busyLN, VECS[i].ebl);
      check($sformatf("R%0d vec%0d busyR", VECS[i].req, i), busyRN, VECS[i].ebr);
      check($sformatf("R%0d vec%0d grantL", VECS[i].req, i), wrGrantL, VECS[i].egl);
      check($sformatf("R%0d vec%0d grantR", VECS[i].req, i), wrGrantR, VECS[i].egr);
    end

    // R7: slave output tracks inputs in the same cycle, between edges
    busyInLN = 1'b0; busyInRN = 1'b1;
    #1;
    check("R7 slave busyL same cycle", busyLN, 1'b0);
    check("R7 slave busyR same cycle", busyRN, 1'b1);

    // R4 tie-right instance on simultaneous rise
    drive('{1'b1,1'b0,1'b0,B,B,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd4});
    @(posedge clk); #2;
    ceL = 1'b1; ceR = 1'b1;
    @(posedge clk); #2;
    check("R4 right-priority busyL", tBusyLN, 1'b0);
    check("R4 right-priority busyR", tBusyRN, 1'b1);

    // R9: asynchronous reset mid-contention releases busy at once
    rstN = 1'b0;
    #1;
    check("R9 async busyL", busyLN, 1'b1);
    check("R9 async busyR", busyRN, 1'b1);
    check("R9 async tie busyL", tBusyLN, 1'b1);
    rstN = 1'b1;

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule